// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block carries out one atomic memory instruction at a time for a 64-bit core. A command brings an operation code, a byte address, a data operand, a destination register index and the current contents of the compare special register. The unit reads the addressed doubleword or word through a request/acknowledge memory port. It may then write a new value. The port stays locked across both accesses, so no other master can come in between.

The old memory value comes back for register writeback on a one-cycle result pulse. A misaligned address, a memory access error or a forbidden destination register ends the operation on a one-cycle fault pulse instead. The fault pulse carries a cause code and the address of the instruction. The operation code is four bits wide. Bit 3 selects the 32-bit form (1) or the 64-bit form (0). Bits 2:0 select the kind: 0 exchange, 1 compare-exchange, 2 fetch-add, 3 fetch-add-if-non-negative, 4 fetch-and, 5 fetch-or. Kinds 6 and 7 read memory and write nothing.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Every operation that completes without a fault pulses `res_valid` for one cycle. `res_data` then holds the value read from memory, and `res_dest` holds the command's destination. Kinds 6 and 7 read memory and never write it.
- R2: Exchange (kind 0) always writes the data operand and takes no notice of the compare input.
- R3: Compare-exchange (kind 1) writes the data operand only when the value read equals the compare value. On a mismatch memory is left unchanged.
- R4: Fetch-add (2), fetch-and (4) and fetch-or (5) write back the old value combined with the operand by sum, bitwise AND or bitwise OR.
- R5: Fetch-add-if-non-negative (3) writes the sum of old value and operand only when the sign bit of the sum is clear. The sign bit is bit 63 in the 64-bit form and bit 31 in the 32-bit form.
- R6: In the 32-bit forms the unit takes `mem_rdata[31:0]` and sign-extends it to 64 bits, ignoring the upper read bits. It compares against the sign-extended low half of the compare input. It drives `mem_wide`=0, so that only `mem_wdata[31:0]` is stored. The 64-bit forms drive `mem_wide`=1.
- R7: A 64-bit form whose address is not a multiple of 8, or a 32-bit form whose address is not a multiple of 4, gives a fault with cause 1 and makes no memory request. The fault pulses in the cycle after acceptance.
- R8: An access error on the read or on the write gives a fault with cause 2 and the command address, and no result pulse.
- R9: Destination 63 (zero register) or 62 (sequence register) completes with `res_valid`=1 and `res_we`=0. Destinations 0 to 55 give `res_we`=1.
- R10: Destinations 56 to 61 (network-port registers) give a fault with cause 3 and the command address. This fault comes after the memory read and any write have taken effect.
- R11: `mem_lock` stays high from the read request until the write is acknowledged or the write is skipped. It is high in every cycle in which `mem_req` is high.
- R12: `busy` is high from acceptance until the cycle of the result or fault pulse. A `cmd_valid` presented while busy is ignored. `res_valid` and `fault` are never high together.
- R13: After reset, `busy`, `mem_req`, `res_valid` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; accepted when not busy |
| cmd_op | input | 4 | Bit 3 selects the 32-bit form; bits 2:0 select the kind |
| cmd_addr | input | AW | Byte address operand |
| cmd_data | input | 64 | Data operand |
| cmd_dest | input | RW | Destination register index |
| cmp_val | input | 64 | Compare special register contents |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| mem_lock | output | 1 | Memory port locked for the atomic sequence |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 64 | Write data (low 32 bits for a 32-bit access) |
| mem_ack | input | 1 | Access done |
| mem_err | input | 1 | Access error, valid with `mem_ack` |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| res_valid | output | 1 | Result pulse |
| res_data | output | 64 | Old memory value, sign-extended in the 32-bit forms |
| res_dest | output | RW | Destination index |
| res_we | output | 1 | Register write enable |
| fault | output | 1 | Fault pulse |
| fault_cause | output | 2 | 1 misaligned, 2 access error, 3 illegal register |
| fault_addr | output | AW | Command address of the faulting instruction |

## Verification
An alignment fault pulses in the cycle after the accepting edge. Any other outcome pulses in the cycle after the last `mem_ack` of the operation. That is the read acknowledge when the write is skipped and the write acknowledge otherwise. The bench drives inputs and samples outputs on falling edges. After each command it polls once per cycle for the first result or fault pulse and checks every field in that same cycle. One cycle later it confirms that the pulse has cleared and that no refused command has started. The memory model acknowledges after a random delay. The bench compares the model's memory against an independently computed image once the operation ends.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int AW       = 32,
  parameter int RW       = 6,
  parameter int ZERO_REG = 63,
  parameter int SEQ_REG  = 62,
  parameter int PORT_LO  = 56,
  parameter int PORT_HI  = 61
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [63:0]   cmd_data,
  input  logic [RW-1:0] cmd_dest,
  input  logic [63:0]   cmp_val,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [63:0]   mem_rdata,
  output logic          res_valid,
  output logic [63:0]   res_data,
  output logic [RW-1:0] res_dest,
  output logic          res_we,
  output logic          fault,
  output logic [1:0]    fault_cause,
  output logic [AW-1:0] fault_addr
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  localparam logic [1:0] C_ALIGN = 2'd1, C_ACC = 2'd2, C_REG = 2'd3;

  st_t           st;
  logic [2:0]    kind;
  logic          narrow;
  logic [AW-1:0] addr;
  logic [63:0]   opnd, cmpv, old, wval;
  logic [RW-1:0] dest;

  wire        misal   = cmd_op[3] ? |cmd_addr[1:0] : |cmd_addr[2:0];
  wire        accept  = cmd_valid && st == S_IDLE;
  wire [63:0] rd_x    = narrow ? {{32{mem_rdata[31]}}, mem_rdata[31:0]} : mem_rdata;
  wire [63:0] cmp_x   = narrow ? {{32{cmpv[31]}}, cmpv[31:0]} : cmpv;
  wire [63:0] sum     = rd_x + opnd;
  wire        sum_neg = narrow ? sum[31] : sum[63];
  wire        d_drop  = dest == RW'(ZERO_REG) || dest == RW'(SEQ_REG);
  wire        d_bad   = dest >= RW'(PORT_LO) && dest <= RW'(PORT_HI);

  logic        do_wr;
  logic [63:0] new_val;
  always_comb begin
    do_wr   = 1'b1;
    new_val = opnd;
    case (kind)
      3'd0: new_val = opnd;
      3'd1: do_wr = (rd_x == cmp_x);
      3'd2: new_val = sum;
      3'd3: begin new_val = sum; do_wr = !sum_neg; end
      3'd4: new_val = rd_x & opnd;
      3'd5: new_val = rd_x | opnd;
      default: do_wr = 1'b0;
    endcase
  end

  wire        ack_ok  = mem_ack && !mem_err;
  wire        done_ok = (st == S_RD && ack_ok && !do_wr) || (st == S_WR && ack_ok);
  wire [63:0] fin_val = (st == S_RD) ? rd_x : old;

  assign busy      = st != S_IDLE;
  assign mem_req   = st != S_IDLE;
  assign mem_lock  = st != S_IDLE;
  assign mem_we    = st == S_WR;
  assign mem_wide  = !narrow;
  assign mem_addr  = addr;
  assign mem_wdata = wval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= '0; narrow <= 1'b0; addr <= '0; opnd <= '0; cmpv <= '0;
      old <= '0; wval <= '0; dest <= '0;
      res_valid <= 1'b0; res_data <= '0; res_dest <= '0; res_we <= 1'b0;
      fault <= 1'b0; fault_cause <= '0; fault_addr <= '0;
    end else begin
      res_valid <= 1'b0;
      fault     <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          kind <= cmd_op[2:0]; narrow <= cmd_op[3]; addr <= cmd_addr;
          opnd <= cmd_data; cmpv <= cmp_val; dest <= cmd_dest;
          if (misal) begin
            fault <= 1'b1; fault_cause <= C_ALIGN; fault_addr <= cmd_addr;
          end else st <= S_RD;
        end
        S_RD: if (mem_ack) begin
          old <= rd_x;
          if (mem_err) begin
            fault <= 1'b1; fault_cause <= C_ACC; fault_addr <= addr; st <= S_IDLE;
          end else if (do_wr) begin
            wval <= new_val; st <= S_WR;
          end else st <= S_IDLE;
        end
        S_WR: if (mem_ack) begin
          st <= S_IDLE;
          if (mem_err) begin
            fault <= 1'b1; fault_cause <= C_ACC; fault_addr <= addr;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (done_ok) begin
        if (d_bad) begin
          fault <= 1'b1; fault_cause <= C_REG; fault_addr <= addr;
        end else begin
          res_valid <= 1'b1; res_data <= fin_val; res_dest <= dest; res_we <= !d_drop;
        end
      end
    end
  end

  a_r7_aligned_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wide ? mem_addr[2:0] == 3'd0 : mem_addr[1:0] == 2'd0));
  a_r11_lock_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && !mem_err) |=> (mem_lock || res_valid || fault));
  a_r12_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || fault) |-> !busy);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && fault));
  a_r9_drop_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_dest == RW'(ZERO_REG) || res_dest == RW'(SEQ_REG))) |-> !res_we);
  a_r5_gez_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && kind == 3'd3) |-> !(mem_wide ? mem_wdata[63] : mem_wdata[31]));
  a_r8_err_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (fault && fault_cause == 2'd2));
endmodule

// File: tb/sim_atomic_rmw_unit.sv
module sim_atomic_rmw_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [31:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0, cmp_val = '0;
  logic [5:0] cmd_dest = '0;
  logic busy, mem_req, mem_we, mem_wide, mem_lock;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic res_valid, res_we, fault;
  logic [63:0] res_data;
  logic [5:0] res_dest;
  logic [1:0] fault_cause;
  logic [31:0] fault_addr;

  atomic_rmw_unit u0 (.*);

  int checks = 0, errors = 0, reqs = 0, lock_bad = 0, dly = 0;
  logic [63:0] mem [16];
  logic [63:0] emem [16];
  logic rd_phase = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_req) reqs++;
    if (mem_req && !mem_lock) lock_bad++;
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (dly == 0) begin
        logic e;
        logic [3:0] i;
        e = mem_addr[8] || (mem_we && mem_addr[9]);
        i = mem_addr[6:3];
        mem_ack <= 1'b1;
        mem_err <= e;
        if (!mem_we) begin
          if (mem_wide) mem_rdata <= mem[i];
          else if (mem_addr[2]) mem_rdata <= {~mem[i][63:32], mem[i][63:32]};
          else mem_rdata <= {~mem[i][31:0], mem[i][31:0]};
        end else if (!e) begin
          if (mem_wide) mem[i] = mem_wdata;
          else if (mem_addr[2]) mem[i][63:32] = mem_wdata[31:0];
          else mem[i][31:0] = mem_wdata[31:0];
        end
        dly = $urandom % 3;
      end else dly = dly - 1;
    end
  end

  always @(negedge clk) begin
    if (rd_phase) begin
      if (!mem_lock && !res_valid && !fault) lock_bad++;
      if (!mem_lock) rd_phase = 1'b0;
    end
    if (mem_req && mem_ack && !mem_we && !mem_err) rd_phase = 1'b1;
  end

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd3: return "R5";
      3'd2, 3'd4, 3'd5: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [63:0] d,
                       input logic [5:0] dst, input logic [63:0] c,
                       output int cause, output logic [63:0] res, output logic we);
    logic n, wr;
    logic [3:0] i;
    logic [63:0] o, cx, s, nv;
    n = op[3]; i = a[6:3]; res = '0; we = 1'b0;
    if (n ? |a[1:0] : |a[2:0]) begin cause = 1; return; end
    if (a[8]) begin cause = 2; return; end
    if (!n) o = emem[i];
    else if (a[2]) o = {{32{emem[i][63]}}, emem[i][63:32]};
    else o = {{32{emem[i][31]}}, emem[i][31:0]};
    cx = n ? {{32{c[31]}}, c[31:0]} : c;
    s = o + d; wr = 1'b1; nv = d;
    case (op[2:0])
      3'd0: nv = d;
      3'd1: wr = (o == cx);
      3'd2: nv = s;
      3'd3: begin nv = s; wr = n ? !s[31] : !s[63]; end
      3'd4: nv = o & d;
      3'd5: nv = o | d;
      default: wr = 1'b0;
    endcase
    if (wr && a[9]) begin cause = 2; return; end
    if (wr) begin
      if (!n) emem[i] = nv;
      else if (a[2]) emem[i][63:32] = nv[31:0];
      else emem[i][31:0] = nv[31:0];
    end
    if (dst >= 56 && dst <= 61) begin cause = 3; return; end
    cause = 0; res = o; we = (dst < 62);
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [63:0] d,
                        input logic [5:0] dst, input logic [63:0] c, input bit poke);
    int cause, n;
    logic [63:0] res;
    logic we;
    bit poked;
    string rq;
    rq = req_of(op[2:0]);
    model(op, a, d, dst, c, cause, res, we);
    poked = 1'b0;
    reqs = 0; lock_bad = 0;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_dest = dst; cmp_val = c; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!res_valid && !fault && n < 60) begin
      if (poke && !poked && busy) begin
        cmd_op = 4'd0; cmd_addr = 32'h0; cmd_data = 64'hBAD0BAD0BAD0BAD0; cmd_dest = 6'd1;
        cmd_valid = 1'b1; poked = 1'b1;
      end else cmd_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    if (cause == 0) begin
      chk(res_valid && !fault, rq, "result pulse", {62'b0, res_valid, fault}, 64'd2);
      chk(res_data == res, rq, "old value", res_data, res);
      chk(res_dest == dst, "R1", "dest", 64'(res_dest), 64'(dst));
      chk(res_we == we, (dst >= 62) ? "R9" : "R1", "res_we", 64'(res_we), 64'(we));
    end else begin
      string fr;
      fr = (cause == 1) ? "R7" : (cause == 2) ? "R8" : "R10";
      chk(fault && !res_valid, fr, "fault pulse", {62'b0, res_valid, fault}, 64'd1);
      chk(fault_cause == 2'(cause), fr, "cause", 64'(fault_cause), 64'(cause));
      chk(fault_addr == a, fr, "fault addr", 64'(fault_addr), 64'(a));
      if (cause == 1) chk(reqs == 0, "R7", "no request", 64'(reqs), 64'd0);
    end
    chk(lock_bad == 0, "R11", "lock held", 64'(lock_bad), 64'd0);
    @(negedge clk);
    chk(!res_valid && !fault && !busy, "R12", "pulse ends, refused cmd idle",
        {61'b0, res_valid, fault, busy}, 64'd0);
    for (int k = 0; k < 16; k++)
      if (mem[k] !== emem[k]) chk(1'b0, rq, "memory image", mem[k], emem[k]);
    checks++;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) begin
      mem[k] = {$urandom, $urandom};
      emem[k] = mem[k];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !res_valid && !fault, "R13", "reset state",
        {60'b0, busy, mem_req, res_valid, fault}, 64'd0);
    rst_n = 1'b1;
    // directed corners
    run_op(4'h0, 32'h08, 64'h1111_2222_3333_4444, 6'd3, 64'h0, 1'b1);      // R2
    run_op(4'h1, 32'h10, 64'hAAAA, 6'd4, emem[2], 1'b0);                   // R3 match
    run_op(4'h1, 32'h10, 64'hBBBB, 6'd4, ~emem[2], 1'b0);                  // R3 mismatch
    emem[3] = 64'h7FFF_FFFF_FFFF_FFF0; mem[3] = emem[3];
    run_op(4'h3, 32'h18, 64'h20, 6'd5, 64'h0, 1'b0);                        // R5 skip 64
    run_op(4'h3, 32'h18, 64'h5, 6'd5, 64'h0, 1'b0);                         // R5 write 64
    emem[4] = 64'h0000_0001_8000_0010; mem[4] = emem[4];
    run_op(4'hB, 32'h20, 64'h1, 6'd6, 64'h0, 1'b0);                         // R5/R6 32 negative skip
    run_op(4'hB, 32'h20, 64'hFFFF_FFFF_8000_0000, 6'd6, 64'h0, 1'b0);       // R6 32 wrap write
    run_op(4'h9, 32'h24, 64'h1234, 6'd6, {32'h0, emem[4][63:32]}, 1'b0);   // R6 compare sext
    run_op(4'h8, 32'h2C, 64'hFFFF_FFFF_CAFE_F00D, 6'd7, 64'h0, 1'b0);       // R6 narrow exchange
    run_op(4'h0, 32'h0C, 64'h1, 6'd1, 64'h0, 1'b0);                         // R7 misaligned 64
    run_op(4'h8, 32'h0E, 64'h1, 6'd1, 64'h0, 1'b0);                         // R7 misaligned 32
    run_op(4'h2, 32'h108, 64'h1, 6'd1, 64'h0, 1'b0);                        // R8 read error
    run_op(4'h0, 32'h208, 64'h1, 6'd1, 64'h0, 1'b0);                        // R8 write error
    run_op(4'h1, 32'h208, 64'h1, 6'd1, ~emem[1], 1'b0);                     // R3 write skipped, no error
    run_op(4'h5, 32'h30, 64'hF0, 6'd63, 64'h0, 1'b0);                       // R9 zero reg
    run_op(4'h4, 32'h30, 64'h0F0F, 6'd62, 64'h0, 1'b0);                     // R9 seq reg
    run_op(4'h2, 32'h38, 64'h3, 6'd57, 64'h0, 1'b0);                        // R10 illegal dest
    run_op(4'h6, 32'h40, 64'h3, 6'd2, 64'h0, 1'b1);                         // R1 read-only kind
    // random
    for (int t = 0; t < 400; t++) begin
      logic [3:0] op;
      logic [31:0] a;
      logic [63:0] d, c;
      logic [5:0] dst;
      op = 4'($urandom % 16);
      a = {22'b0, ($urandom % 8 == 0), ($urandom % 8 == 0), 1'b0, 4'($urandom), 3'b000};
      if ($urandom % 8 == 0) a[2:0] = 3'($urandom);
      else if (op[3]) a[2] = 1'($urandom);
      d = ($urandom % 2) ? {$urandom, $urandom} : 64'($signed(32'($urandom % 64) - 32'sd32));
      dst = ($urandom % 6 == 0) ? 6'(56 + $urandom % 8) : 6'($urandom % 56);
      if ($urandom % 2) begin
        if (!op[3]) c = emem[a[6:3]];
        else c = a[2] ? {32'h0, emem[a[6:3]][63:32]} : {32'h0, emem[a[6:3]][31:0]};
      end else c = {$urandom, $urandom};
      run_op(op, a, d, dst, c, ($urandom % 4 == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule